// File: doc/BRIEF.md
# Compact Byte-Word Codec

This block packs a short run of bytes into one 32-bit word and unpacks such a word again. The run length is not sent as a separate field. When fewer than four bytes are carried, the unused upper byte lanes are filled with reserved marker values, and those values tell the receiver how many lanes hold data. A word without a marker pattern carries four bytes.

The encoder is offered up to four candidate bytes and a count. It returns the word and the number of bytes it actually took. If four bytes are offered but their upper lanes happen to look like a marker pattern, the encoder takes only the first three. The caller then offers the fourth byte again in the next word. The decoder takes any word and returns the bytes and a count from 1 to 4.

Both directions run side by side and are independent of each other. Each result is registered once at the output of the block.

Top module: `byte_word_codec`

## Requirements
- R1: Byte k of the offered run (k = 0..3) sits in word bits [8k+7:8k], with the first byte in bits 7:0.
- R2: Encoding one byte gives 0x80 in each of bits 31:24, 23:16 and 15:8, and reports 1 byte used.
- R3: Encoding two bytes gives 0x81 in bits 31:24 and in bits 23:16, and reports 2 bytes used.
- R4: Encoding three bytes gives 0x82 in bits 31:24, and reports 3 bytes used.
- R5: Four bytes are sent unchanged, with 4 bytes used, when all three of these hold: bits 31:8 are not 0x808080, bits 31:16 are not 0x8181, and bits 31:24 are not 0x82.
- R6: Four bytes that match any of those patterns are sent in the 3-byte form (0x82 in bits 31:24, the first three bytes below it), with 3 bytes used.
- R7: An encoder count of 0 sets the error output, reports 0 used and gives a word of 0.
- R8: An encoder count from 5 to 7 is treated as 4.
- R9: Byte lanes at or above the count have no effect on the encoded word.
- R10: The decoder tests the 1-byte pattern first, then the 2-byte pattern, then the 3-byte pattern. A word that matches none of them decodes to 4 bytes.
- R11: Decoder output lanes at or above the decoded count are 0.
- R12: Decoding an encoded word gives back exactly the bytes used, and a count equal to the used count.
- R13: All outputs are registered. They are 0 during reset, and each result appears on the first rising clock edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_bytes_i | input | 32 | Candidate bytes; first byte in bits 7:0 |
| enc_cnt_i | input | 3 | Number of bytes offered (0 is illegal) |
| enc_word_o | output | 32 | Encoded word |
| enc_used_o | output | 3 | Number of bytes the word carries |
| enc_err_o | output | 1 | Illegal count of zero |
| dec_word_i | input | 32 | Word to decode |
| dec_bytes_o | output | 32 | Decoded bytes; unused lanes are zero |
| dec_cnt_o | output | 3 | Decoded byte count, 1 to 4 |

## Verification
Every encoder and decoder result is due one rising edge after its inputs are driven. The bench drives inputs on the falling edge and compares one time unit after the next rising edge, so each result is read exactly one register stage after its stimulus. The round-trip phase feeds a captured encoded word back into the decoder on a later falling edge and compares two edges after the first stimulus. That count covers both output registers on the path.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned LANES     = 4;
  localparam int unsigned WORD_W    = LANE_W * LANES;
  localparam int unsigned CNT_W     = 3;
  localparam logic [LANE_W-1:0] MARK_BASE = 8'h80;

  // Length carried by a word: lanes L..LANES-1 all equal MARK_BASE+L-1 means L bytes.
  function automatic logic [CNT_W-1:0] word_len(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] len;
    logic             hit;
    len = CNT_W'(LANES);
    for (int l = LANES - 1; l >= 1; l--) begin
      hit = 1'b1;
      for (int k = l; k < LANES; k++)
        if (w[k*LANE_W +: LANE_W] != MARK_BASE + LANE_W'(l - 1)) hit = 1'b0;
      if (hit) len = CNT_W'(l); // shortest pattern checked last wins priority
    end
    return len;
  endfunction
endpackage

// File: rtl/bwc_enc.sv
module bwc_enc
  import bwc_pkg::*;
(
  input  logic [WORD_W-1:0] bytes_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  used_o,
  output logic              err_o
);
  logic [CNT_W-1:0]  n_eff;
  logic [CNT_W-1:0]  len;
  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] packed_w;
  logic              collide;

  assign n_eff = (cnt_i > CNT_W'(LANES)) ? CNT_W'(LANES) : cnt_i;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign masked[g*LANE_W +: LANE_W] =
      (CNT_W'(g) < n_eff) ? bytes_i[g*LANE_W +: LANE_W] : '0;
  end

  // a full word that reads as a short one must drop to the 3-byte form
  assign collide = (word_len(masked) != CNT_W'(LANES));
  assign len     = (n_eff == CNT_W'(LANES) && collide) ? CNT_W'(LANES - 1) : n_eff;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign packed_w[g*LANE_W +: LANE_W] =
      (CNT_W'(g) < len) ? masked[g*LANE_W +: LANE_W]
                        : MARK_BASE + LANE_W'(len) - LANE_W'(1);
  end

  assign err_o  = (n_eff == '0);
  assign used_o = err_o ? '0 : len;
  assign word_o = err_o ? '0 : packed_w;
endmodule

// File: rtl/bwc_dec.sv
module bwc_dec
  import bwc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] bytes_o,
  output logic [CNT_W-1:0]  cnt_o
);
  assign cnt_o = word_len(word_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bytes_o[g*LANE_W +: LANE_W] =
      (CNT_W'(g) < cnt_o) ? word_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/byte_word_codec.sv
module byte_word_codec
  import bwc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] enc_bytes_i,
  input  logic [CNT_W-1:0]  enc_cnt_i,
  output logic [WORD_W-1:0] enc_word_o,
  output logic [CNT_W-1:0]  enc_used_o,
  output logic              enc_err_o,
  input  logic [WORD_W-1:0] dec_word_i,
  output logic [WORD_W-1:0] dec_bytes_o,
  output logic [CNT_W-1:0]  dec_cnt_o
);
  logic [WORD_W-1:0] enc_word_d, dec_bytes_d;
  logic [CNT_W-1:0]  enc_used_d, dec_cnt_d;
  logic              enc_err_d;

  bwc_enc u_enc (
    .bytes_i (enc_bytes_i),
    .cnt_i   (enc_cnt_i),
    .word_o  (enc_word_d),
    .used_o  (enc_used_d),
    .err_o   (enc_err_d)
  );

  bwc_dec u_dec (
    .word_i  (dec_word_i),
    .bytes_o (dec_bytes_d),
    .cnt_o   (dec_cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_word_o  <= '0;
      enc_used_o  <= '0;
      enc_err_o   <= 1'b0;
      dec_bytes_o <= '0;
      dec_cnt_o   <= '0;
    end else begin
      enc_word_o  <= enc_word_d;
      enc_used_o  <= enc_used_d;
      enc_err_o   <= enc_err_d;
      dec_bytes_o <= dec_bytes_d;
      dec_cnt_o   <= dec_cnt_d;
    end
  end
endmodule

// File: rtl/byte_word_codec_chk.sv
module byte_word_codec_chk
  import bwc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] enc_word_o,
  input logic [CNT_W-1:0]  enc_used_o,
  input logic              enc_err_o,
  input logic [WORD_W-1:0] dec_bytes_o,
  input logic [CNT_W-1:0]  dec_cnt_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;

  logic [WORD_W-1:0] rt_bytes;
  logic [CNT_W-1:0]  rt_cnt;
  bwc_dec u_rt (.word_i(enc_word_o), .bytes_o(rt_bytes), .cnt_o(rt_cnt));

  p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    enc_err_o |-> (enc_used_o == '0 && enc_word_o == '0));

  p_used_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    !enc_err_o |-> (enc_used_o >= 3'd1 && enc_used_o <= 3'd4));

  p_dec_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    dec_cnt_o >= 3'd1 && dec_cnt_o <= 3'd4);

  p_full_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (enc_used_o == 3'd4) |-> (enc_word_o[31:8] != 24'h808080 &&
                              enc_word_o[31:16] != 16'h8181 &&
                              enc_word_o[31:24] != 8'h82));

  p_one_mark_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (enc_used_o == 3'd1) |-> (enc_word_o[31:8] == 24'h808080));

  p_two_mark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (enc_used_o == 3'd2) |-> (enc_word_o[31:16] == 16'h8181));

  p_three_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (enc_used_o == 3'd3) |-> (enc_word_o[31:24] == 8'h82));

  p_round_trip_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    !enc_err_o |-> (rt_cnt == enc_used_o));

  p_dec_zero_lanes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed)
    (dec_cnt_o == 3'd1) |-> (dec_bytes_o[31:8] == 24'h0));
endmodule

bind byte_word_codec byte_word_codec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enc_word_o  (enc_word_o),
  .enc_used_o  (enc_used_o),
  .enc_err_o   (enc_err_o),
  .dec_bytes_o (dec_bytes_o),
  .dec_cnt_o   (dec_cnt_o)
);

// File: tb/byte_word_codec_tb_top.sv
module byte_word_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_bytes = '0;
  logic [2:0]  enc_cnt = 3'd1;
  logic [31:0] enc_word;
  logic [2:0]  enc_used;
  logic        enc_err;
  logic [31:0] dec_word = '0;
  logic [31:0] dec_bytes;
  logic [2:0]  dec_cnt;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  byte_word_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_bytes_i(enc_bytes), .enc_cnt_i(enc_cnt),
    .enc_word_o(enc_word), .enc_used_o(enc_used), .enc_err_o(enc_err),
    .dec_word_i(dec_word), .dec_bytes_o(dec_bytes), .dec_cnt_o(dec_cnt)
  );

  typedef struct {
    logic [31:0] word;
    logic [2:0]  used;
    logic        err;
    logic [31:0] dbytes;
    logic [2:0]  dcnt;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [2:0] c,
                       input logic [31:0] xw, input logic [2:0] xu, input logic xe,
                       input logic [31:0] dw, input logic [31:0] xdb, input logic [2:0] xdc,
                       input string tag);
    exp_t e;
    @(negedge clk);
    enc_bytes = b; enc_cnt = c; dec_word = dw;
    e.word = xw; e.used = xu; e.err = xe; e.dbytes = xdb; e.dcnt = xdc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: result due one edge after the falling-edge drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({enc_word, enc_used, enc_err} == {e.word, e.used, e.err}, e.tag,
              $sformatf("enc %h/%0d/%0b", enc_word, enc_used, enc_err),
              $sformatf("enc %h/%0d/%0b", e.word, e.used, e.err));
        check({dec_bytes, dec_cnt} == {e.dbytes, e.dcnt}, e.tag,
              $sformatf("dec %h/%0d", dec_bytes, dec_cnt),
              $sformatf("dec %h/%0d", e.dbytes, e.dcnt));
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    check({enc_word, enc_used, enc_err, dec_bytes, dec_cnt} == '0, "R13 reset",
          $sformatf("%h %0d %0b %h %0d", enc_word, enc_used, enc_err, dec_bytes, dec_cnt), "all zero");
    rst_n = 1'b1;

    drive(32'hDDCCBBAA, 3'd1, 32'h808080AA, 3'd1, 1'b0, 32'h808080AA, 32'h000000AA, 3'd1, "R2 R9 R13 one byte");
    drive(32'hDDCCBBAA, 3'd2, 32'h8181BBAA, 3'd2, 1'b0, 32'h8181BBAA, 32'h0000BBAA, 3'd2, "R3 R11 two bytes");
    drive(32'hDDCCBBAA, 3'd3, 32'h82CCBBAA, 3'd3, 1'b0, 32'h82CCBBAA, 32'h00CCBBAA, 3'd3, "R4 three bytes");
    drive(32'hDDCCBBAA, 3'd4, 32'hDDCCBBAA, 3'd4, 1'b0, 32'hDDCCBBAA, 32'hDDCCBBAA, 3'd4, "R1 R5 four bytes");
    drive(32'h82112233, 3'd4, 32'h82112233, 3'd3, 1'b0, 32'h82112233, 32'h00112233, 3'd3, "R6 top 0x82 fallback");
    drive(32'h81813344, 3'd4, 32'h82813344, 3'd3, 1'b0, 32'h81813344, 32'h00003344, 3'd2, "R6 0x8181 fallback");
    drive(32'h80808055, 3'd4, 32'h82808055, 3'd3, 1'b0, 32'h80808055, 32'h00000055, 3'd1, "R6 R10 0x808080 fallback");
    drive(32'h12345678, 3'd0, 32'h00000000, 3'd0, 1'b1, 32'h00000000, 32'h00000000, 3'd4, "R7 zero count");
    drive(32'h12345678, 3'd7, 32'h12345678, 3'd4, 1'b0, 32'h82818080, 32'h00818080, 3'd3, "R8 R10 count 7, 0x82 tested last");
    drive(32'h80000000, 3'd5, 32'h80000000, 3'd4, 1'b0, 32'h81808080, 32'h81808080, 3'd4, "R8 R10 no pattern");
    drive(32'h82FFFF01, 3'd1, 32'h80808001, 3'd1, 1'b0, 32'h80818181, 32'h80818181, 3'd4, "R9 R10 ignored lanes");
    drive(32'h81817777, 3'd2, 32'h81817777, 3'd2, 1'b0, 32'h8281FF00, 32'h0081FF00, 3'd3, "R9 R3 R10");
    @(negedge clk); @(negedge clk);

    // round trip: capture encoded word, decode it, compare with used prefix
    lcg = 32'h1ACE_B00C;
    for (int i = 0; i < 48; i++) begin
      logic [31:0] b, w, want;
      logic [2:0]  c, u;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      b = lcg;
      if (i % 4 == 0) b[31:24] = 8'h82;
      if (i % 8 == 1) b[31:16] = 16'h8181;
      if (i % 8 == 5) b[31:8]  = 24'h808080;
      c = 3'(1 + (i % 4));
      @(negedge clk);
      enc_bytes = b; enc_cnt = c;
      @(negedge clk);
      w = enc_word; u = enc_used;
      dec_word = w;
      @(negedge clk);
      want = '0;
      for (int k = 0; k < 4; k++) if (k < u) want[k*8 +: 8] = b[k*8 +: 8];
      check(u >= 3'd1 && u <= c, "R12 used within offer", $sformatf("%0d", u), $sformatf("1..%0d", c));
      check(dec_bytes == want && dec_cnt == u, "R12 round trip",
            $sformatf("%h/%0d", dec_bytes, dec_cnt), $sformatf("%h/%0d", want, u));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule